// File: doc/BRIEF.md
# Atomic Processor Core Allocator

This block owns the running/free state of a pool of processor cores and is the only place where a core can be claimed, started or halted. Any requester (normally one of the cores) may present one command per clock: claim any idle core ("new"), start or restart a named core ("init"), or halt a named core ("stop"). Each command carries a program address. When a core is started, the allocator emits a one-clock start pulse for that core together with the address to start from. When a core is halted, it emits a one-clock stop pulse. Loading the program and running the core are handled elsewhere.

All commands presented in one clock are resolved in that same clock, in a fixed order from requester 0 upward. Each command sees the pool as the commands before it left it. The search for a free core and the claim of that core are one hardware step, so two requesters can never be handed the same core. Every request is accepted in the cycle it is presented; there is no back-pressure and no ready signal. The answer appears on the response pins one clock later and lasts for one clock.

Command encoding on `req_op`: 0 = new, 1 = init, 2 = stop, 3 = reserved.

Top module: `core_alloc`

## Requirements
- R1: After reset every core is free (`core_busy` all zero), and no start pulse, stop pulse or response is present.
- R2: A new command (op 0) is answered one clock later with `rsp_ok`=1 and `rsp_id` set to the lowest-numbered core that is available to it. That core becomes busy, gets a start pulse, and its `core_addr` field takes the command's address.
- R3: When several new commands occur in one clock, each is given a different core, in ascending order of requester index.
- R4: A new command that finds no available core is answered with `rsp_ok`=0 and `rsp_id`=0. It causes no start pulse and does not change `core_busy`.
- R5: An init command (op 1) starts the named core even when it is already running. The answer is `rsp_ok`=1 with `rsp_id` set to the named core, and the command gives a start pulse and a new `core_addr` value.
- R6: A stop command (op 2) clears the named core's busy bit, gives a stop pulse and is answered with `rsp_ok`=1. A new command in a later clock can claim that core.
- R7: A core that is stopped in a clock cannot be claimed by a new command in that same clock.
- R8: Within one clock, a core named by an init from a lower-indexed requester cannot be chosen by a later new command. When two commands touch the same core in one clock, the higher-indexed requester decides the core's final state and pulse.
- R9: A reserved command (op 3) is answered with `rsp_ok`=0 and has no effect on busy bits, pulses or addresses.
- R10: Start pulses, stop pulses and `rsp_valid` last exactly one clock for each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NREQ | Per-requester command present this clock |
| req_op | input | 2*NREQ | Per-requester command code (0 new, 1 init, 2 stop, 3 reserved) |
| req_id | input | ID_W*NREQ | Per-requester target core for init/stop |
| req_addr | input | ADDR_W*NREQ | Per-requester program address for a start |
| rsp_valid | output | NREQ | Answer present, one clock after the command |
| rsp_ok | output | NREQ | Command succeeded |
| rsp_id | output | ID_W*NREQ | Core that was claimed, started or stopped |
| core_start | output | NCORES | One-clock start pulse per core |
| core_stop | output | NCORES | One-clock stop pulse per core |
| core_addr | output | ADDR_W*NCORES | Start address per core, held until the next start |
| core_busy | output | NCORES | Running state per core |

## Verification
The bench builds the allocator with four cores, four requesters and 8-bit addresses. With this size, three requesters can fill most of the pool in one clock, and exhaustion is reached after a couple of commands. With four requesters, a single clock can hold an init, a new, a second init on the newly claimed core and a stop. This brings the same-clock ordering cases of R3, R7 and R8 within reach of short directed sequences.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  typedef enum logic [1:0] {
    OP_NEW  = 2'd0,
    OP_INIT = 2'd1,
    OP_STOP = 2'd2,
    OP_RSVD = 2'd3
  } alloc_op_e;
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[k]) idx = W'(k);
    end
  end
endmodule

// File: rtl/alloc_step.sv
module alloc_step
  import alloc_pkg::*;
#(
  parameter int NCORES = 16,
  parameter int ADDR_W = 16,
  parameter int ID_W   = $clog2(NCORES)
) (
  input  logic                     valid,
  input  logic [1:0]               op,
  input  logic [ID_W-1:0]          id,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NCORES-1:0]        avail_in,
  input  logic [NCORES-1:0]        busy_in,
  input  logic [NCORES-1:0]        start_in,
  input  logic [NCORES-1:0]        stop_in,
  input  logic [NCORES*ADDR_W-1:0] caddr_in,
  output logic [NCORES-1:0]        avail_out,
  output logic [NCORES-1:0]        busy_out,
  output logic [NCORES-1:0]        start_out,
  output logic [NCORES-1:0]        stop_out,
  output logic [NCORES*ADDR_W-1:0] caddr_out,
  output logic                     ok,
  output logic                     is_new,
  output logic [ID_W-1:0]          rid
);
  logic            pick_found;
  logic [ID_W-1:0] pick_idx;

  lowest_pick #(.N(NCORES), .W(ID_W)) pick_i (
    .vec(avail_in), .found(pick_found), .idx(pick_idx)
  );

  always_comb begin
    avail_out = avail_in;
    busy_out  = busy_in;
    start_out = start_in;
    stop_out  = stop_in;
    caddr_out = caddr_in;
    ok        = 1'b0;
    is_new    = 1'b0;
    rid       = '0;
    if (valid) begin
      case (alloc_op_e'(op))
        OP_NEW: begin
          is_new = 1'b1;
          if (pick_found) begin
            avail_out[pick_idx] = 1'b0;
            busy_out[pick_idx]  = 1'b1;
            start_out[pick_idx] = 1'b1;
            stop_out[pick_idx]  = 1'b0;
            caddr_out[pick_idx*ADDR_W +: ADDR_W] = addr;
            ok  = 1'b1;
            rid = pick_idx;
          end
        end
        OP_INIT: begin
          avail_out[id] = 1'b0;
          busy_out[id]  = 1'b1;
          start_out[id] = 1'b1;
          stop_out[id]  = 1'b0;
          caddr_out[id*ADDR_W +: ADDR_W] = addr;
          ok  = 1'b1;
          rid = id;
        end
        OP_STOP: begin
          avail_out[id] = 1'b0;  // freed only from the next clock on
          busy_out[id]  = 1'b0;
          start_out[id] = 1'b0;
          stop_out[id]  = 1'b1;
          ok  = 1'b1;
          rid = id;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/core_alloc.sv
module core_alloc #(
  parameter int NCORES = 16,
  parameter int NREQ   = 16,
  parameter int ADDR_W = 16,
  localparam int ID_W  = $clog2(NCORES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [2*NREQ-1:0]        req_op,
  input  logic [ID_W*NREQ-1:0]     req_id,
  input  logic [ADDR_W*NREQ-1:0]   req_addr,
  output logic [NREQ-1:0]          rsp_valid,
  output logic [NREQ-1:0]          rsp_ok,
  output logic [ID_W*NREQ-1:0]     rsp_id,
  output logic [NCORES-1:0]        core_start,
  output logic [NCORES-1:0]        core_stop,
  output logic [NCORES*ADDR_W-1:0] core_addr,
  output logic [NCORES-1:0]        core_busy
);
  logic [NCORES-1:0]        busy_q, start_q, stop_q, busy_d;
  logic [NCORES*ADDR_W-1:0] addr_q;
  logic [NREQ-1:0]          rv_q, ok_q, new_q;
  logic [ID_W*NREQ-1:0]     rid_q;

  logic [NCORES-1:0]        avail_c [NREQ+1];
  logic [NCORES-1:0]        busy_c  [NREQ+1];
  logic [NCORES-1:0]        start_c [NREQ+1];
  logic [NCORES-1:0]        stop_c  [NREQ+1];
  logic [NCORES*ADDR_W-1:0] caddr_c [NREQ+1];
  logic [NREQ-1:0]          ok_c, new_c;
  logic [ID_W*NREQ-1:0]     rid_c;

  assign avail_c[0] = ~busy_q;
  assign busy_c[0]  = busy_q;
  assign start_c[0] = '0;
  assign stop_c[0]  = '0;
  assign caddr_c[0] = addr_q;

  for (genvar i = 0; i < NREQ; i++) begin : g_step
    alloc_step #(.NCORES(NCORES), .ADDR_W(ADDR_W), .ID_W(ID_W)) step_i (
      .valid    (req_valid[i]),
      .op       (req_op[2*i +: 2]),
      .id       (req_id[ID_W*i +: ID_W]),
      .addr     (req_addr[ADDR_W*i +: ADDR_W]),
      .avail_in (avail_c[i]),
      .busy_in  (busy_c[i]),
      .start_in (start_c[i]),
      .stop_in  (stop_c[i]),
      .caddr_in (caddr_c[i]),
      .avail_out(avail_c[i+1]),
      .busy_out (busy_c[i+1]),
      .start_out(start_c[i+1]),
      .stop_out (stop_c[i+1]),
      .caddr_out(caddr_c[i+1]),
      .ok       (ok_c[i]),
      .is_new   (new_c[i]),
      .rid      (rid_c[ID_W*i +: ID_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      busy_d  <= '0;
      start_q <= '0;
      stop_q  <= '0;
      addr_q  <= '0;
      rv_q    <= '0;
      ok_q    <= '0;
      new_q   <= '0;
      rid_q   <= '0;
    end else begin
      busy_d  <= busy_q;
      busy_q  <= busy_c[NREQ];
      start_q <= start_c[NREQ];
      stop_q  <= stop_c[NREQ];
      addr_q  <= caddr_c[NREQ];
      rv_q    <= req_valid;
      ok_q    <= ok_c;
      new_q   <= new_c & req_valid;
      rid_q   <= rid_c;
    end
  end

  assign rsp_valid  = rv_q;
  assign rsp_ok     = ok_q;
  assign rsp_id     = rid_q;
  assign core_start = start_q;
  assign core_stop  = stop_q;
  assign core_addr  = addr_q;
  assign core_busy  = busy_q;

  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    // A successful claim took a core that was not running before
    assert_new_was_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rv_q[i] && new_q[i] && ok_q[i]) |-> !busy_d[rid_q[ID_W*i +: ID_W]]);
    for (genvar j = i + 1; j < NREQ; j++) begin : g_pair
      assert_claim_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rv_q[i] && new_q[i] && ok_q[i] && rv_q[j] && new_q[j] && ok_q[j])
        |-> (rid_q[ID_W*i +: ID_W] != rid_q[ID_W*j +: ID_W]));
    end
  end

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      core_start[c] |-> core_busy[c]);
    assert_stop_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      core_stop[c] |-> !core_busy[c]);
  end
endmodule

// File: tb/core_alloc_tb_top.sv
module core_alloc_tb_top;
  localparam int NC = 4;
  localparam int NR = 4;
  localparam int AW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]    req_valid = '0;
  logic [2*NR-1:0]  req_op = '0;
  logic [IW*NR-1:0] req_id = '0;
  logic [AW*NR-1:0] req_addr = '0;
  logic [NR-1:0]    rsp_valid, rsp_ok;
  logic [IW*NR-1:0] rsp_id;
  logic [NC-1:0]    core_start, core_stop, core_busy;
  logic [NC*AW-1:0] core_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  core_alloc #(.NCORES(NC), .NREQ(NR), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_id(req_id), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_id(rsp_id), .core_start(core_start),
    .core_stop(core_stop), .core_addr(core_addr), .core_busy(core_busy)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(int r, logic [1:0] op, logic [IW-1:0] id, logic [AW-1:0] a);
    req_valid[r] = 1'b1;
    req_op[2*r +: 2] = op;
    req_id[IW*r +: IW] = id;
    req_addr[AW*r +: AW] = a;
  endtask

  // apply queued commands at the falling edge, sample just after the rising edge
  task automatic fire();
    logic [NR-1:0] v;
    logic [2*NR-1:0] o;
    logic [IW*NR-1:0] d;
    logic [AW*NR-1:0] a;
    v = req_valid; o = req_op; d = req_id; a = req_addr;
    req_valid = '0; req_op = '0; req_id = '0; req_addr = '0;
    @(negedge clk);
    req_valid = v; req_op = o; req_id = d; req_addr = a;
    @(posedge clk); #1;
    req_valid = '0; req_op = '0; req_id = '0; req_addr = '0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  function automatic logic [IW-1:0] rid(int r);
    return rsp_id[IW*r +: IW];
  endfunction

  task automatic t_reset();
    check("R1 busy", 32'(core_busy), 0);
    check("R1 start", 32'(core_start), 0);
    check("R1 stop", 32'(core_stop), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_new_single();
    put(0, 2'd0, 2'd3, 8'h11);
    fire();
    check("R2 rsp_valid", 32'(rsp_valid), 32'b0001);
    check("R2 ok", 32'(rsp_ok[0]), 1);
    check("R2 id", 32'(rid(0)), 0);
    check("R2 start", 32'(core_start), 32'b0001);
    check("R2 addr", 32'(core_addr[0 +: AW]), 32'h11);
    check("R2 busy", 32'(core_busy), 32'b0001);
    idle();
    check("R10 start", 32'(core_start), 0);
    check("R10 rsp_valid", 32'(rsp_valid), 0);
    check("R10 busy held", 32'(core_busy), 32'b0001);
  endtask

  task automatic t_new_many();
    put(1, 2'd0, 0, 8'h21);
    put(2, 2'd0, 0, 8'h22);
    put(3, 2'd0, 0, 8'h23);
    fire();
    check("R3 ok", 32'(rsp_ok), 32'b1110);
    check("R3 id1", 32'(rid(1)), 1);
    check("R3 id2", 32'(rid(2)), 2);
    check("R3 id3", 32'(rid(3)), 3);
    check("R3 start", 32'(core_start), 32'b1110);
    check("R3 addr3", 32'(core_addr[3*AW +: AW]), 32'h23);
    check("R3 busy", 32'(core_busy), 32'b1111);
  endtask

  task automatic t_full();
    put(0, 2'd0, 0, 8'h99);
    fire();
    check("R4 valid", 32'(rsp_valid), 32'b0001);
    check("R4 ok", 32'(rsp_ok), 0);
    check("R4 id", 32'(rid(0)), 0);
    check("R4 start", 32'(core_start), 0);
    check("R4 busy", 32'(core_busy), 32'b1111);
    check("R4 addr0", 32'(core_addr[0 +: AW]), 32'h11);
  endtask

  task automatic t_init_running();
    put(2, 2'd1, 2'd1, 8'h55);
    fire();
    check("R5 ok", 32'(rsp_ok), 32'b0100);
    check("R5 id", 32'(rid(2)), 1);
    check("R5 start", 32'(core_start), 32'b0010);
    check("R5 addr", 32'(core_addr[1*AW +: AW]), 32'h55);
    check("R5 busy", 32'(core_busy), 32'b1111);
  endtask

  task automatic t_stop_then_new();
    put(0, 2'd2, 2'd2, 0);
    put(1, 2'd0, 0, 8'h66);
    fire();
    check("R6 stop ok", 32'(rsp_ok[0]), 1);
    check("R6 stop id", 32'(rid(0)), 2);
    check("R6 stop pulse", 32'(core_stop), 32'b0100);
    check("R6 busy", 32'(core_busy), 32'b1011);
    check("R7 same-clock new fails", 32'(rsp_ok[1]), 0);
    check("R7 no start", 32'(core_start), 0);
    put(3, 2'd0, 0, 8'h77);
    fire();
    check("R10 stop pulse gone", 32'(core_stop), 0);
    check("R6 reclaim ok", 32'(rsp_ok[3]), 1);
    check("R6 reclaim id", 32'(rid(3)), 2);
    check("R6 reclaim busy", 32'(core_busy), 32'b1111);
  endtask

  task automatic t_reserved();
    put(0, 2'd3, 2'd0, 8'hEE);
    fire();
    check("R9 valid", 32'(rsp_valid), 32'b0001);
    check("R9 ok", 32'(rsp_ok), 0);
    check("R9 busy", 32'(core_busy), 32'b1111);
    check("R9 pulses", 32'({core_start, core_stop}), 0);
    check("R9 addr0", 32'(core_addr[0 +: AW]), 32'h11);
    for (int r = 0; r < NR; r++) put(r, 2'd2, IW'(r), 0);
    fire();
    check("R6 all stopped", 32'(core_busy), 0);
    check("R6 all stop pulses", 32'(core_stop), 32'b1111);
  endtask

  task automatic t_order();
    put(0, 2'd1, 2'd0, 8'hA0);
    put(1, 2'd0, 0, 8'hA1);
    put(2, 2'd1, 2'd1, 8'hA2);
    put(3, 2'd2, 2'd0, 0);
    fire();
    check("R8 new skips init core", 32'(rid(1)), 1);
    check("R8 ok", 32'(rsp_ok), 32'b1111);
    check("R8 busy", 32'(core_busy), 32'b0010);
    check("R8 start", 32'(core_start), 32'b0010);
    check("R8 stop", 32'(core_stop), 32'b0001);
    check("R8 later addr wins", 32'(core_addr[1*AW +: AW]), 32'hA2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_new_single();
    t_new_many();
    t_full();
    t_init_running();
    t_stop_then_new();
    t_reserved();
    t_order();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule